// File: doc/BRIEF.md
# Multi-Mode Trigger Gate

This block turns two digitized level comparisons into a trigger gate for a sweep generator. Each clock it looks at whether the trigger signal sits above or below the trigger level and applies the set and reset rules of one of four selectable gate modes. The modes are an edge mode that must be armed first and is cut off by holdoff, a slow compare mode that waits for the status feedback to go false, a fast compare mode that follows the displacement, and a strobe-qualified compare mode. A registered status output follows the gate one clock later.

Each delay sweep has its own slope setting. Software-side logic writes a per-sweep slope bit, and the `active_sweep` input picks which stored slope applies at any moment. The comparators, level DACs and ramp generation sit outside the block.

Top module: `trig_gate`

## Requirements
- R1: After reset, `gate` and `status` are 0, the arm state is clear, the mode register holds 00 and every stored slope is 0 (rising).
- R2: With slope 0, "in direction" means `above_lvl`=1 and `below_lvl`=0, and "opposite" means `below_lvl`=1 and `above_lvl`=0. Slope 1 swaps the two. When both comparator bits are equal, there is no displacement and the gate holds its value.
- R3: In mode 00 (sweep), an opposite displacement while the gate is clear and holdoff is low arms the block. A later in-direction displacement with holdoff low sets the gate at the next edge and disarms.
- R4: In mode 00, an in-direction displacement with no prior arming leaves the gate clear.
- R5: In mode 00, holdoff high clears the gate and the arm state at the next edge and blocks any set in that cycle.
- R6: In mode 01 (slow compare), the gate sets when `status_fb` is 0 and the displacement is in direction, and it resets on an opposite displacement. With `status_fb`=1 it does not set.
- R7: In mode 10 (fast compare), the gate sets on an in-direction displacement and resets on an opposite one.
- R8: In mode 11 (strobed fast compare), the gate sets only when `strobe` is 1 and the displacement is opposite, and it resets on an in-direction displacement.
- R9: In a cycle where `mode` differs from the stored mode, the next edge clears the gate and the arm state and loads the new mode. The new rules apply from the following cycle.
- R10: `status` equals the value `gate` had one clock earlier.
- R11: With `slope_wr`=1, `slope_wr_fall` is stored as the slope of sweep `slope_wr_sel`. The gate rules use the stored slope of sweep `active_sweep`, and a write takes effect from the cycle after it.
- R12: `holdoff` has no effect outside mode 00, and `strobe` has no effect outside mode 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| above_lvl | input | 1 | Trigger signal is above the level |
| below_lvl | input | 1 | Trigger signal is below the level |
| mode | input | 2 | Gate mode: 00 sweep, 01 slow compare, 10 fast compare, 11 strobed fast compare |
| holdoff | input | 1 | Trigger holdoff |
| strobe | input | 1 | Trigger strobe |
| status_fb | input | 1 | Trigger status feedback |
| slope_wr | input | 1 | Write enable for a stored slope |
| slope_wr_sel | input | SEL_W | Sweep whose slope is written |
| slope_wr_fall | input | 1 | Slope value written (1 = falling) |
| active_sweep | input | SEL_W | Sweep whose slope is in use |
| gate | output | 1 | Trigger gate |
| status | output | 1 | Gate delayed by one clock |

## Verification
The hardest state to reach is a sweep-mode set. It needs an opposite excursion and then an in-direction one. Holdoff must stay low across both, and the mode and the active slope must not change between them. Uniform random stimulus rarely lines this up. The bench therefore drives it directly, and it keeps holdoff and mode changes rare in the random phase so that armed windows survive long enough for a crossing. A reference model updated each cycle checks both outputs, and the stored slope is switched between sweeps during the run.

// File: rtl/trig_gate.sv
module trig_gate #(
  parameter int NUM_SWEEPS = 2,
  parameter int SEL_W = (NUM_SWEEPS > 1) ? $clog2(NUM_SWEEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             above_lvl,
  input  logic             below_lvl,
  input  logic [1:0]       mode,
  input  logic             holdoff,
  input  logic             strobe,
  input  logic             status_fb,
  input  logic             slope_wr,
  input  logic [SEL_W-1:0] slope_wr_sel,
  input  logic             slope_wr_fall,
  input  logic [SEL_W-1:0] active_sweep,
  output logic             gate,
  output logic             status
);
  localparam logic [1:0] M_SWEEP = 2'b00;
  localparam logic [1:0] M_SLOW  = 2'b01;
  localparam logic [1:0] M_FAST  = 2'b10;
  localparam logic [1:0] M_STRB  = 2'b11;

  logic [NUM_SWEEPS-1:0] slope_q;
  logic [1:0] mode_q;
  logic gate_q, arm_q, stat_q;
  logic set_c, clr_c;

  wire fall     = slope_q[active_sweep];
  wire disp     = above_lvl ^ below_lvl;
  wire with_dir = disp & (fall ? below_lvl : above_lvl);
  wire against  = disp & ~with_dir;
  wire mode_chg = mode != mode_q;

  always_comb begin
    set_c = 1'b0;
    clr_c = 1'b0;
    case (mode_q)
      M_SWEEP: begin set_c = arm_q & with_dir & ~holdoff; clr_c = holdoff; end
      M_SLOW:  begin set_c = ~status_fb & with_dir;       clr_c = against; end
      M_FAST:  begin set_c = with_dir;                    clr_c = against; end
      M_STRB:  begin set_c = strobe & against;            clr_c = with_dir; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_SWEEP;
      gate_q <= 1'b0;
      arm_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      stat_q <= gate_q;
      mode_q <= mode;
      if (mode_chg || clr_c)  gate_q <= 1'b0;
      else if (set_c)         gate_q <= 1'b1;
      if (mode_chg || holdoff || mode_q != M_SWEEP || set_c) arm_q <= 1'b0;
      else if (!gate_q && against)                           arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slope_q <= '0;
    else begin
      for (int i = 0; i < NUM_SWEEPS; i++)
        if (slope_wr && slope_wr_sel == SEL_W'(i)) slope_q[i] <= slope_wr_fall;
    end
  end

  assign gate   = gate_q;
  assign status = stat_q;
endmodule

module trig_gate_chk #(
  parameter int NUM_SWEEPS = 2,
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             above_lvl,
  input logic             below_lvl,
  input logic [1:0]       mode,
  input logic             holdoff,
  input logic             strobe,
  input logic [SEL_W-1:0] active_sweep,
  input logic [NUM_SWEEPS-1:0] slope_q,
  input logic [1:0]       mode_q,
  input logic             arm_q,
  input logic             gate,
  input logic             status
);
  wire fall = slope_q[active_sweep];
  wire in_d = (above_lvl != below_lvl) && (fall ? below_lvl : above_lvl);
  wire op_d = (above_lvl != below_lvl) && !in_d;

  // R10
  status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status == $past(gate));
  // R5
  holdoff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && mode_q == 2'b00 && holdoff) |=> (!gate && !arm_q));
  // R9
  mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (!gate && !arm_q && mode_q == $past(mode)));
  // R7
  fast_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && mode_q == 2'b10 && (in_d || op_d)) |=> gate == $past(in_d));
  // R8
  strobe_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate) && $past(mode_q) == 2'b11) |-> $past(strobe) && $past(op_d));
  // R3
  sweep_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate) && $past(mode_q) == 2'b00) |-> $past(arm_q) && $past(in_d));
  // R3
  arm_gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate && arm_q));
  // R2
  no_disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (above_lvl == below_lvl && mode == mode_q && !(mode_q == 2'b00 && holdoff)) |=> $stable(gate));
endmodule

bind trig_gate trig_gate_chk #(.NUM_SWEEPS(NUM_SWEEPS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .above_lvl(above_lvl), .below_lvl(below_lvl),
  .mode(mode), .holdoff(holdoff), .strobe(strobe), .active_sweep(active_sweep),
  .slope_q(slope_q), .mode_q(mode_q), .arm_q(arm_q), .gate(gate), .status(status));

// File: tb/trig_gate_test.sv
`timescale 1ns/1ps
module trig_gate_test;
  localparam int NS = 2;
  localparam int SW = 1;

  logic clk = 0, rst_n = 0;
  logic above_lvl = 0, below_lvl = 0, holdoff = 0, strobe = 0, status_fb = 0;
  logic slope_wr = 0, slope_wr_fall = 0;
  logic [1:0] mode = 0;
  logic [SW-1:0] slope_wr_sel = 0, active_sweep = 0;
  logic gate, status;

  int checks = 0, fails = 0;
  logic e_gate, e_arm, e_stat;
  logic [1:0] e_mode;
  logic [NS-1:0] e_slope;

  always #5 clk = ~clk;

  trig_gate #(.NUM_SWEEPS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .above_lvl(above_lvl), .below_lvl(below_lvl),
    .mode(mode), .holdoff(holdoff), .strobe(strobe), .status_fb(status_fb),
    .slope_wr(slope_wr), .slope_wr_sel(slope_wr_sel), .slope_wr_fall(slope_wr_fall),
    .active_sweep(active_sweep), .gate(gate), .status(status));

  function automatic logic in_dir(logic a, logic b, logic f);
    return (a != b) && (f ? b : a);
  endfunction

  function automatic logic opp_dir(logic a, logic b, logic f);
    return (a != b) && !(f ? b : a);
  endfunction

  task automatic model_step();
    logic f, ind, opd, s, c;
    f = e_slope[active_sweep];
    ind = in_dir(above_lvl, below_lvl, f);
    opd = opp_dir(above_lvl, below_lvl, f);
    s = 0; c = 0;
    case (e_mode)
      2'b00: begin s = e_arm && ind && !holdoff; c = holdoff; end
      2'b01: begin s = !status_fb && ind; c = opd; end
      2'b10: begin s = ind; c = opd; end
      default: begin s = strobe && opd; c = ind; end
    endcase
    e_stat = e_gate;
    if (mode != e_mode) begin e_gate = 0; e_arm = 0; end
    else begin
      if (e_mode != 2'b00 || holdoff || s) e_arm = 0;
      else if (!e_gate && opd) e_arm = 1;
      if (c) e_gate = 0; else if (s) e_gate = 1;
    end
    e_mode = mode;
    if (slope_wr) e_slope[slope_wr_sel] = slope_wr_fall;
  endtask

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    model_step();
    @(negedge clk);
    check(tag, gate, e_gate, "gate");
    check("R10", status, e_stat, "status");
    slope_wr = 0;
  endtask

  task automatic drive(logic a, logic b, logic h, logic st, logic [1:0] m);
    above_lvl = a; below_lvl = b; holdoff = h; strobe = st; mode = m;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    string tg;
    seed = 32'd7;
    void'($urandom(seed));
    e_gate = 0; e_arm = 0; e_stat = 0; e_mode = 0; e_slope = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", gate, 1'b0, "gate after reset");
    check("R1", status, 1'b0, "status after reset");

    // R4: in-direction without arming
    drive(1, 0, 0, 0, 2'b00); step("R4"); step("R4");
    check("R4", gate, 1'b0, "unarmed gate");
    // R3: arm then cross
    drive(0, 1, 0, 0, 2'b00); step("R3");
    drive(1, 0, 0, 0, 2'b00); step("R3");
    check("R3", gate, 1'b1, "armed crossing");
    // R2: no displacement holds
    drive(1, 1, 0, 0, 2'b00); step("R2");
    check("R2", gate, 1'b1, "both comparators");
    // R5: holdoff clears and blocks
    drive(1, 0, 1, 0, 2'b00); step("R5");
    check("R5", gate, 1'b0, "holdoff clear");
    drive(0, 1, 1, 0, 2'b00); step("R5");
    drive(1, 0, 0, 0, 2'b00); step("R5");
    check("R5", gate, 1'b0, "arm blocked by holdoff");
    // R9: mode change clears
    drive(1, 0, 0, 0, 2'b10); step("R9");
    check("R9", gate, 1'b0, "mode change cycle");
    step("R7");
    check("R7", gate, 1'b1, "fast set");
    // R12: holdoff ignored in fast mode
    drive(1, 0, 1, 0, 2'b10); step("R12");
    check("R12", gate, 1'b1, "holdoff ignored");
    drive(0, 1, 0, 0, 2'b10); step("R7");
    check("R7", gate, 1'b0, "fast reset");
    // R11: falling slope on sweep 1
    slope_wr = 1; slope_wr_sel = 1; slope_wr_fall = 1; active_sweep = 1;
    drive(0, 0, 0, 0, 2'b10); step("R11");
    drive(0, 1, 0, 0, 2'b10); step("R11");
    check("R11", gate, 1'b1, "falling slope set");
    active_sweep = 0; step("R11");
    check("R11", gate, 1'b0, "sweep 0 rising");
    // R6: slow compare
    status_fb = 1; drive(1, 0, 0, 0, 2'b01); step("R9"); step("R6");
    check("R6", gate, 1'b0, "status_fb blocks");
    status_fb = 0; step("R6");
    check("R6", gate, 1'b1, "slow set");
    // R8 and R12: strobe
    drive(0, 1, 0, 0, 2'b11); step("R9"); step("R12");
    check("R12", gate, 1'b0, "no strobe");
    drive(0, 1, 0, 1, 2'b11); step("R8");
    check("R8", gate, 1'b1, "strobed set");
    drive(1, 0, 0, 1, 2'b11); step("R8");
    check("R8", gate, 1'b0, "strobed reset");

    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 64 == 0) mode = 2'($urandom);
      above_lvl = 1'($urandom); below_lvl = 1'($urandom);
      holdoff = ($urandom % 8 == 0);
      strobe = ($urandom % 4 == 0);
      status_fb = 1'($urandom);
      if ($urandom % 16 == 0) begin
        slope_wr = 1; slope_wr_sel = 1'($urandom); slope_wr_fall = 1'($urandom);
      end
      if ($urandom % 32 == 0) active_sweep = 1'($urandom);
      case (e_mode)
        2'b00: tg = "R3"; 2'b01: tg = "R6"; 2'b10: tg = "R7"; default: tg = "R8";
      endcase
      if (mode != e_mode) tg = "R9";
      step(tg);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule